// File: doc/BRIEF.md
# Dual-Bus Masked Watchpoint Unit

This block gives a Harvard-architecture core a pair of hardware breakpoint and watchpoint comparators. Each comparator holds a value and a mask for three fields: address, data and access attributes. Every cycle, each comparator looks at either the instruction-fetch bus or the data-access bus, whichever its control register picks. A mask bit of 1 makes the matching value bit don't-care.

A hit is registered. When the comparator is watching the fetch bus, the hit appears on that comparator's instruction-breakpoint output. When it is watching the data bus, the hit appears on its data-watchpoint output. The bus-select bit can never be masked.

A debug register port reaches all comparator registers through one address, one write-data word, a write enable and a combinational read-data word. The same port also reaches a few core debug registers: control, status, vector-catch control and communications control.

Top module: `dbgwp_top`

## Requirements
- R1: The block holds NUNITS independent comparators (default 2), and each drives its own bit of `ibrk_hit` and of `dwp_hit`.
- R2: Comparator u has its registers at address 16+8u plus an offset: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. The address and data registers are full width and read back what was written.
- R3: A field matches when ((bus XOR value) AND NOT mask) is zero. A comparator hits only when the address, data and attribute fields all match.
- R4: Control-mask bit 3 always reads 0, and writing 1 to it has no effect. Control-mask bits [2:0] are writable. Bits above these read 0.
- R5: Control-value layout: bit 0 is write, bits [2:1] are size, bit 3 is bus select, bit 4 is enable.
  - With select=0, the comparator uses `if_addr`, `if_opcode` and attributes {`if_size`, 0}.
  - With select=1, it uses `da_addr`, `da_data` and attributes {`da_size`, `da_write`}.
  - The other bus has no effect.
- R6: A hit drives `ibrk_hit[u]` when select=0 and `dwp_hit[u]` when select=1. The unselected output stays 0.
- R7: A hit appears on the clock edge that follows the qualifying cycle and lasts one cycle. A transaction with its valid strobe low never hits.
- R8: With enable (control-value bit 4) at 0, both outputs of that comparator stay 0.
- R9: Address 0 is a 6-bit read/write debug control register. Address 2 is an 8-bit read/write vector-catch register.
- R10: Address 1 reads the 5-bit `status_in`, and address 4 reads the 6-bit `comms_in`. Writes to either address change nothing.
- R11: After reset, every register reads 0 and no output is high.
- R12: Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Debug register address |
| reg_wr_en | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| status_in | input | 5 | Core debug status, read at address 1 |
| comms_in | input | 6 | Comms control flags, read at address 4 |
| if_valid | input | 1 | Instruction fetch qualifier |
| if_addr | input | 32 | Fetch address |
| if_opcode | input | 32 | Fetched opcode |
| if_size | input | 2 | Fetch size |
| da_valid | input | 1 | Data access qualifier |
| da_addr | input | 32 | Load/store address |
| da_data | input | 32 | Load or store data |
| da_size | input | 2 | Access size |
| da_write | input | 1 | 1 = store, 0 = load |
| ibrk_hit | output | 2 | Per-comparator instruction breakpoint |
| dwp_hit | output | 2 | Per-comparator data watchpoint |

## Verification
The bench builds the block with its default parameters: two comparators with 32-bit address and data fields. This lets one comparator watch the fetch bus while the other watches the data bus, and it lets a vector drive both buses at once so that the two comparators can be seen hitting independently in the same cycle. The 32-bit width makes a wide partial address mask and an all-ones data mask reachable. It also makes full-width read-back of the value registers possible.

// File: rtl/dbgwp_pkg.sv
// Shared constants for the watchpoint block: control-field layout and
// register offsets. Assumes the comparator attribute field is 3 bits.
package dbgwp_pkg;
    localparam int CTL_W   = 5;   // control value width
    localparam int CMP_W   = 3;   // compared attribute bits
    localparam int SEL_BIT = 3;   // bus select (1 = data bus)
    localparam int EN_BIT  = 4;   // comparator enable

    localparam logic [2:0] OFF_AVAL = 3'd0;
    localparam logic [2:0] OFF_AMSK = 3'd1;
    localparam logic [2:0] OFF_DVAL = 3'd2;
    localparam logic [2:0] OFF_DMSK = 3'd3;
    localparam logic [2:0] OFF_CVAL = 3'd4;
    localparam logic [2:0] OFF_CMSK = 3'd5;

    localparam int UNIT_BASE = 16;
    localparam int UNIT_STEP = 8;
endpackage

// File: rtl/wp_field_cmp.sv
// Masked equality on one field: a mask bit of 1 makes that bit don't-care.
// Assumes value and mask are stable registers; purely combinational.
module wp_field_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] bus,
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    output logic         hit
);
    // Reduce the unmasked differing bits.
    always_comb hit = ~|((bus ^ val) & ~msk);
endmodule

// File: rtl/dbg_core_regs.sv
// Core debug registers: control (RW), status (RO), vector catch (RW),
// comms control (RO). Assumes reg_addr decode is exact; others read 0.
module dbg_core_regs #(
    parameter int RAW  = 5,
    parameter int DW   = 32,
    parameter int CT_W = 6,
    parameter int ST_W = 5,
    parameter int VC_W = 8,
    parameter int CM_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  reg_addr,
    input  logic            wr_en,
    input  logic [CT_W-1:0] wr_ctl,
    input  logic [VC_W-1:0] wr_vc,
    input  logic [ST_W-1:0] status_in,
    input  logic [CM_W-1:0] comms_in,
    output logic [DW-1:0]   rd_data
);
    localparam logic [RAW-1:0] A_CTL = RAW'(0);
    localparam logic [RAW-1:0] A_ST  = RAW'(1);
    localparam logic [RAW-1:0] A_VC  = RAW'(2);
    localparam logic [RAW-1:0] A_CM  = RAW'(4);

    logic [CT_W-1:0] ctl_q;
    logic [VC_W-1:0] vc_q;

    // Write the two read/write registers; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            vc_q  <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_CTL) ctl_q <= wr_ctl;
            if (reg_addr == A_VC)  vc_q  <= wr_vc;
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            A_CTL:   rd_data = DW'(ctl_q);
            A_ST:    rd_data = DW'(status_in);
            A_VC:    rd_data = DW'(vc_q);
            A_CM:    rd_data = DW'(comms_in);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wp_unit.sv
// One breakpoint/watchpoint comparator with its value and mask registers.
// Control bit SEL_BIT picks the bus and the output; it is never maskable.
// Assumes BASE is aligned to 8 so offsets sit in the low three address bits.
module wp_unit
    import dbgwp_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int RAW  = 5,
    parameter int BASE = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] reg_addr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    input  logic           if_valid,
    input  logic [AW-1:0]  if_addr,
    input  logic [DW-1:0]  if_opcode,
    input  logic [1:0]     if_size,
    input  logic           da_valid,
    input  logic [AW-1:0]  da_addr,
    input  logic [DW-1:0]  da_data,
    input  logic [1:0]     da_size,
    input  logic           da_write,
    output logic           ibrk_hit,
    output logic           dwp_hit
);
    localparam logic [RAW-1:0] BASE_V = RAW'(BASE);

    logic [AW-1:0]    aval_q, amsk_q;
    logic [DW-1:0]    dval_q, dmsk_q;
    logic [CTL_W-1:0] cval_q;
    logic [CMP_W-1:0] cmsk_q;

    logic             in_blk;
    logic [2:0]       off;
    logic [AW-1:0]    cmp_addr;
    logic [DW-1:0]    cmp_data;
    logic [CMP_W-1:0] cmp_attr;
    logic             cmp_valid;
    logic             hit_a, hit_d, hit_c;

    // Decode whether the address falls in this comparator's window.
    always_comb begin
        in_blk = (reg_addr[RAW-1:3] == BASE_V[RAW-1:3]);
        off    = reg_addr[2:0];
    end

    // Register writes; the stored control mask omits the select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aval_q <= '0; amsk_q <= '0;
            dval_q <= '0; dmsk_q <= '0;
            cval_q <= '0; cmsk_q <= '0;
        end else if (wr_en && in_blk) begin
            unique case (off)
                OFF_AVAL: aval_q <= wr_data[AW-1:0];
                OFF_AMSK: amsk_q <= wr_data[AW-1:0];
                OFF_DVAL: dval_q <= wr_data;
                OFF_DMSK: dmsk_q <= wr_data;
                OFF_CVAL: cval_q <= wr_data[CTL_W-1:0];
                OFF_CMSK: cmsk_q <= wr_data[CMP_W-1:0];
                default:  ;
            endcase
        end
    end

    // Read-back; control-mask bit 3 and above read zero.
    always_comb begin
        rd_data = '0;
        if (in_blk) begin
            unique case (off)
                OFF_AVAL: rd_data = DW'(aval_q);
                OFF_AMSK: rd_data = DW'(amsk_q);
                OFF_DVAL: rd_data = dval_q;
                OFF_DMSK: rd_data = dmsk_q;
                OFF_CVAL: rd_data = DW'(cval_q);
                OFF_CMSK: rd_data = DW'(cmsk_q);
                default:  rd_data = '0;
            endcase
        end
    end

    // Steer the selected bus into the comparators.
    always_comb begin
        if (cval_q[SEL_BIT]) begin
            cmp_addr  = da_addr;
            cmp_data  = da_data;
            cmp_attr  = {da_size, da_write};
            cmp_valid = da_valid;
        end else begin
            cmp_addr  = if_addr;
            cmp_data  = if_opcode;
            cmp_attr  = {if_size, 1'b0};
            cmp_valid = if_valid;
        end
    end

    wp_field_cmp #(.W(AW)) u_cmp_addr (
        .bus(cmp_addr), .val(aval_q), .msk(amsk_q), .hit(hit_a));
    wp_field_cmp #(.W(DW)) u_cmp_data (
        .bus(cmp_data), .val(dval_q), .msk(dmsk_q), .hit(hit_d));
    wp_field_cmp #(.W(CMP_W)) u_cmp_attr (
        .bus(cmp_attr), .val(cval_q[CMP_W-1:0]), .msk(cmsk_q), .hit(hit_c));

    // Register the qualified match onto the output the select bit picks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibrk_hit <= 1'b0;
            dwp_hit  <= 1'b0;
        end else begin
            ibrk_hit <= cval_q[EN_BIT] && cmp_valid && hit_a && hit_d && hit_c
                        && !cval_q[SEL_BIT];
            dwp_hit  <= cval_q[EN_BIT] && cmp_valid && hit_a && hit_d && hit_c
                        && cval_q[SEL_BIT];
        end
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ibrk_hit && dwp_hit)); // R6
    AST_IBRK_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibrk_hit) |-> $past(if_valid && !cval_q[SEL_BIT])); // R7
    AST_DWP_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dwp_hit) |-> $past(da_valid && cval_q[SEL_BIT])); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cval_q[EN_BIT] |=> (!ibrk_hit && !dwp_hit)); // R8
    AST_SEL_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && off == OFF_CMSK) |-> !rd_data[SEL_BIT]); // R4
endmodule

// File: rtl/dbgwp_top.sv
// Top of the watchpoint block: NUNITS comparators plus the core debug
// registers behind one shared register port with a combinational read.
// Assumes NUNITS comparators fit the register address space (RAW bits).
module dbgwp_top #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RAW    = 5,
    parameter int NUNITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW-1:0]    reg_addr,
    input  logic              reg_wr_en,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [4:0]        status_in,
    input  logic [5:0]        comms_in,
    input  logic              if_valid,
    input  logic [AW-1:0]     if_addr,
    input  logic [DW-1:0]     if_opcode,
    input  logic [1:0]        if_size,
    input  logic              da_valid,
    input  logic [AW-1:0]     da_addr,
    input  logic [DW-1:0]     da_data,
    input  logic [1:0]        da_size,
    input  logic              da_write,
    output logic [NUNITS-1:0] ibrk_hit,
    output logic [NUNITS-1:0] dwp_hit
);
    import dbgwp_pkg::*;

    localparam int CT_W = 6;
    localparam int VC_W = 8;

    logic [DW-1:0] core_rd;
    logic [DW-1:0] unit_rd [NUNITS];

    dbg_core_regs #(
        .RAW(RAW), .DW(DW), .CT_W(CT_W), .ST_W(5), .VC_W(VC_W), .CM_W(6)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(reg_wr_en),
        .wr_ctl(reg_wdata[CT_W-1:0]), .wr_vc(reg_wdata[VC_W-1:0]),
        .status_in(status_in), .comms_in(comms_in), .rd_data(core_rd));

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        wp_unit #(
            .AW(AW), .DW(DW), .RAW(RAW), .BASE(UNIT_BASE + UNIT_STEP * u)
        ) u_wp (
            .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
            .wr_en(reg_wr_en), .wr_data(reg_wdata), .rd_data(unit_rd[u]),
            .if_valid(if_valid), .if_addr(if_addr), .if_opcode(if_opcode),
            .if_size(if_size), .da_valid(da_valid), .da_addr(da_addr),
            .da_data(da_data), .da_size(da_size), .da_write(da_write),
            .ibrk_hit(ibrk_hit[u]), .dwp_hit(dwp_hit[u]));
    end

    // Merge read data; only the addressed source drives nonzero.
    always_comb begin
        reg_rdata = core_rd;
        for (int u = 0; u < NUNITS; u++) reg_rdata = reg_rdata | unit_rd[u];
    end
endmodule

// File: tb/tb_dbgwp_top.sv
module tb_dbgwp_top;
    localparam int CLK_P = 10;
    localparam int NV    = 9;
    // {iv, ia16, iop16, isz2, dv, da16, dd16, dsz2, dwr, exp_ib2, exp_dw2}
    localparam logic [74:0] VEC [NV] = '{
        {1'b1,16'h1034,16'h0000,2'b10, 1'b0,16'h0000,16'h0000,2'b00,1'b0, 2'b01,2'b00},
        {1'b1,16'h1134,16'h0000,2'b10, 1'b0,16'h0000,16'h0000,2'b00,1'b0, 2'b00,2'b00},
        {1'b0,16'h1000,16'h0000,2'b10, 1'b0,16'h0000,16'h0000,2'b00,1'b0, 2'b00,2'b00},
        {1'b0,16'h0000,16'h0000,2'b00, 1'b1,16'h2000,16'h12AB,2'b00,1'b1, 2'b00,2'b10},
        {1'b0,16'h0000,16'h0000,2'b00, 1'b1,16'h2000,16'h12AB,2'b00,1'b0, 2'b00,2'b00},
        {1'b0,16'h0000,16'h0000,2'b00, 1'b1,16'h2000,16'h12AB,2'b01,1'b1, 2'b00,2'b00},
        {1'b0,16'h0000,16'h0000,2'b00, 1'b1,16'h2000,16'h12AC,2'b00,1'b1, 2'b00,2'b00},
        {1'b1,16'h10FF,16'hBEEF,2'b01, 1'b1,16'h2000,16'h55AB,2'b00,1'b1, 2'b01,2'b10},
        {1'b0,16'h0000,16'h0000,2'b00, 1'b1,16'h1000,16'h0000,2'b00,1'b0, 2'b00,2'b00}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [4:0]  status_in = 5'h15;
    logic [5:0]  comms_in = 6'h2A;
    logic        if_valid = 1'b0, da_valid = 1'b0, da_write = 1'b0;
    logic [31:0] if_addr = '0, if_opcode = '0, da_addr = '0, da_data = '0;
    logic [1:0]  if_size = '0, da_size = '0;
    logic [1:0]  ibrk_hit, dwp_hit;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    dbgwp_top dut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic bus_idle();
        if_valid = 1'b0; da_valid = 1'b0;
    endtask

    // Apply one cycle of bus traffic, check hits registered at the next edge.
    task automatic apply(input logic [74:0] v, input string req);
        @(negedge clk);
        {if_valid, if_addr[15:0], if_opcode[15:0], if_size,
         da_valid, da_addr[15:0], da_data[15:0], da_size, da_write} = v[74:4];
        @(posedge clk); #1;
        chk(req, {28'h0, ibrk_hit, dwp_hit}, {28'h0, v[3:0]});
        bus_idle();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11: reset state
        rd_chk("R11 ctl", 5'd0, 32'h0);
        rd_chk("R11 vcatch", 5'd2, 32'h0);
        for (int a = 16; a < 30; a++) rd_chk("R11 unit regs", 5'(a), 32'h0);
        chk("R11 outputs", {28'h0, ibrk_hit, dwp_hit}, 32'h0);
        // R9 / R10 / R12: core registers
        wr(5'd0, 32'hFFFF_FFFF); rd_chk("R9 ctl 6-bit", 5'd0, 32'h3F);
        wr(5'd2, 32'h0000_01A5); rd_chk("R9 vcatch 8-bit", 5'd2, 32'hA5);
        wr(5'd1, 32'hFFFF_FFFF); rd_chk("R10 status", 5'd1, 32'h15);
        wr(5'd4, 32'hFFFF_FFFF); rd_chk("R10 comms", 5'd4, 32'h2A);
        rd_chk("R12 unmapped", 5'd3, 32'h0);
        rd_chk("R12 unmapped unit off", 5'd22, 32'h0);
        // R2 / R4: unit registers
        wr(5'd26, 32'hDEAD_BEEF); rd_chk("R2 u1 data val", 5'd26, 32'hDEAD_BEEF);
        wr(5'd21, 32'h0000_000F); rd_chk("R4 cmask bit3", 5'd21, 32'h7);
        // Program unit0: fetch, addr 0x1000 mask 0xFF, data and attrs don't care
        wr(5'd16, 32'h1000); wr(5'd17, 32'hFF);
        wr(5'd19, 32'hFFFF_FFFF); wr(5'd20, 32'h10);
        // Program unit1: data, addr 0x2000, low byte 0xAB, byte store
        wr(5'd24, 32'h2000); wr(5'd25, 32'h0);
        wr(5'd26, 32'h0000_00AB); wr(5'd27, 32'hFFFF_FF00);
        wr(5'd28, 32'h19); wr(5'd29, 32'h0);
        rd_chk("R5 u1 cval", 5'd28, 32'h19);
        // Vector table: R1 R3 R5 R6 R7
        for (int i = 0; i < NV; i++) apply(VEC[i], "R3 R5 R6 R7 vector");
        // R7: hit lasts one cycle
        @(posedge clk); #1;
        chk("R7 one cycle", {28'h0, ibrk_hit, dwp_hit}, 32'h0);
        // R8: disabled unit0 stays quiet
        wr(5'd20, 32'h00);
        apply({1'b1,16'h1034,16'h0,2'b10, 1'b0,16'h0,16'h0,2'b00,1'b0, 2'b00,2'b00},
              "R8 disabled");
        // R5 / R6: unit0 switched to data bus, fetch bus no longer matters
        wr(5'd20, 32'h18);
        apply({1'b1,16'h1050,16'h0,2'b10, 1'b0,16'h0,16'h0,2'b00,1'b0, 2'b00,2'b00},
              "R5 fetch ignored");
        apply({1'b0,16'h0,16'h0,2'b00, 1'b1,16'h1050,16'h0,2'b11,1'b1, 2'b00,2'b01},
              "R6 data route u0");
        // R11: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R11 reset again", 5'd20, 32'h0);
        rd_chk("R11 vcatch again", 5'd2, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule